// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer Bank

This peripheral holds one shared prescaler and a parameterised number of independent down-counting timers behind a simple APB-style register port. The prescaler divides the system clock. It produces one tick every (prescaler reload + 1) clocks, and every enabled timer decrements on that tick. A timer that counts past zero either reloads itself from its reload register (periodic mode) or clears its own enable bit and stops (one-shot mode). It can raise an interrupt: the block sets a sticky pending flag and drives a single-cycle pulse on an interrupt line.

A read-only configuration word lets software find out how the block was built. It reports the number of timers, the base interrupt number, whether each timer has its own interrupt line, and the freeze-disable option. Counters and reload registers may be narrower than 32 bits, and bits that do not exist read back as zero. Software can therefore find the implemented width by writing all ones and reading the value back. Chain and debug-halt bits are stored and can be read back in each control register. They do not change how the timer counts.

The register map is as follows:
- 0x00: prescaler current value.
- 0x04: prescaler reload.
- 0x08: configuration word.
- Timer n starts at 0x10 + 16·n, with the counter at +0, the reload at +4 and the control register at +8.

Top module: `pscl_timer_bank`

## Requirements
- R1: The prescaler counts down once per clock and reloads from its reload register (offset 0x04) after reaching zero. Timers therefore advance once every (reload + 1) clocks. The current prescaler value (offset 0x00) never reads above the reload value, and the reload register reads back what was written.
- R2: The configuration word at 0x08 has the timer count in bits 2:0, the base interrupt number in bits 7:3, the separate-line flag in bit 8 and the freeze-disable flag in bit 9. All other bits are zero, and writes to this word have no effect.
- R3: The control register bit positions are: enable = bit 0, restart = bit 1, load = bit 2, interrupt enable = bit 3, pending = bit 4, chain = bit 5, debug halt = bit 6. The load bit always reads as 0.
- R4: Writing a control word with the load bit set copies the timer's reload value into its counter in that cycle.
- R5: An enabled timer with restart set reloads when its counter passes zero. Successive underflows are (timer reload + 1)·(prescaler reload + 1) clocks apart.
- R6: An enabled timer without restart clears its enable bit on underflow and leaves its counter at 0.
- R7: An underflow with interrupt enable set sets the pending bit and gives exactly one clock-long pulse on the timer's interrupt line.
- R8: Writing 1 to the pending bit clears it, and writing 0 leaves it unchanged. An underflow in the same cycle as a clearing write wins.
- R9: An underflow with interrupt enable clear sets no pending bit and produces no pulse.
- R10: When the separate-line flag is set, timer n pulses line base + n. Otherwise every timer pulses line base, and no other line ever pulses.
- R11: Counter and reload registers keep only their low CNT_W bits, and the upper bits read as 0.
- R12: The chain and debug-halt bits read back as written and leave the counting period unchanged.
- R13: The bus has no wait states. pready is always 1, and read data is valid in the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always ready |
| irq | output | N_IRQ | Interrupt pulse lines |

## Verification
The bound checker watches properties that hold in every cycle:
- After a non-zero prescaler reload, a tick is never followed directly by another tick.
- Every interrupt pulse is matched by a set pending flag and by an interrupt enable that was set in the cycle of the underflow.
- A timer's enable bit falls on its own only when restart is clear.
- No interrupt line pulses while no timer fires.

Only the directed scenarios can show the quantities the checker does not track. These are the exact underflow spacing for several prescaler and reload pairs, the write-one-to-clear behaviour, the width truncation on read-back, the read-only configuration word, and which line each timer reaches in separate and shared builds.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // control word bit positions (software-visible)
  localparam int CB_EN = 0;
  localparam int CB_RS = 1;
  localparam int CB_LD = 2;
  localparam int CB_IE = 3;
  localparam int CB_IP = 4;
  localparam int CB_CH = 5;
  localparam int CB_DH = 6;
  localparam int CTL_W = 7;

  // word slot inside a 16-byte block
  typedef enum logic [1:0] {
    SLOT_A = 2'd0,   // global: prescaler value / timer: counter
    SLOT_B = 2'd1,   // global: prescaler reload / timer: reload
    SLOT_C = 2'd2,   // global: config / timer: control
    SLOT_X = 2'd3
  } slot_e;

  typedef struct packed {
    logic dh;
    logic ch;
    logic ip;
    logic ie;
    logic rs;
    logic en;
  } ctl_t;
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             val_we,
  input  logic             rld_we,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] val,
  output logic [PRE_W-1:0] rld,
  output logic             tick
);
  // tick is issued in the cycle the down-counter sits at zero
  assign tick = (val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      rld <= '0;
    end else begin
      if (rld_we) rld <= wdata;
      if (val_we)      val <= wdata;
      else if (tick)   val <= rld;
      else             val <= val - 1'b1;
    end
  end
endmodule

// File: rtl/pscl_timer_chan.sv
module pscl_timer_chan
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CTL_W-1:0] wctl,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output ctl_t             ctl,
  output logic             fire
);
  logic uflow;
  assign uflow = tick & ctl.en & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rld  <= '0;
      ctl  <= '0;
      fire <= 1'b0;
    end else begin
      // counter: bus write, then load, then count
      if (cnt_we)                    cnt <= wdata;
      else if (ctl_we && wctl[CB_LD]) cnt <= rld;
      else if (tick && ctl.en) begin
        if (cnt != '0)   cnt <= cnt - 1'b1;
        else if (ctl.rs) cnt <= rld;
      end

      if (rld_we) rld <= wdata;

      // control fields
      if (ctl_we) begin
        ctl.en <= wctl[CB_EN];
        ctl.rs <= wctl[CB_RS];
        ctl.ie <= wctl[CB_IE];
        ctl.ch <= wctl[CB_CH];
        ctl.dh <= wctl[CB_DH];
        if (wctl[CB_IP]) ctl.ip <= 1'b0;
      end else if (uflow && !ctl.rs) begin
        ctl.en <= 1'b0;
      end

      // underflow event takes priority over a clearing write
      if (uflow && ctl.ie) ctl.ip <= 1'b1;
      fire <= uflow & ctl.ie;
    end
  end
endmodule

// File: rtl/pscl_timer_bank.sv
module pscl_timer_bank
  import pscl_timer_pkg::*;
#(
  parameter int N_TMR     = 3,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 16,
  parameter int IRQ_BASE  = 5,
  parameter bit SEP_IRQ   = 1'b1,
  parameter bit NO_FREEZE = 1'b0,
  parameter int N_IRQ     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [N_IRQ-1:0]  irq
);
  localparam int LAST_LINE = SEP_IRQ ? IRQ_BASE + N_TMR - 1 : IRQ_BASE;
  localparam logic [DATA_W-1:0] CFG_WORD =
    {22'd0, NO_FREEZE, SEP_IRQ, 5'(IRQ_BASE), 3'(N_TMR)};

  initial begin
    if (N_TMR < 1 || N_TMR > 7)      $error("N_TMR must be 1..7");
    if (LAST_LINE >= N_IRQ)          $error("interrupt line out of range");
    if (CNT_W > DATA_W || PRE_W > DATA_W) $error("width too large");
  end

  // ---------------- bus decode ----------------
  logic [3:0] blk;
  slot_e      slot;
  logic       wr_cyc, rd_setup;
  assign blk      = paddr[7:4];
  assign slot     = slot_e'(paddr[3:2]);
  assign wr_cyc   = psel & penable & pwrite & (paddr[1:0] == 2'b00);
  assign rd_setup = psel & ~penable & ~pwrite;
  assign pready   = 1'b1;

  logic pre_val_we, pre_rld_we, tick;
  logic [PRE_W-1:0] pre_val, pre_rld;
  assign pre_val_we = wr_cyc & (blk == 4'd0) & (slot == SLOT_A);
  assign pre_rld_we = wr_cyc & (blk == 4'd0) & (slot == SLOT_B);

  pscl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .val_we (pre_val_we),
    .rld_we (pre_rld_we),
    .wdata  (pwdata[PRE_W-1:0]),
    .val    (pre_val),
    .rld    (pre_rld),
    .tick   (tick)
  );

  // ---------------- timer channels ----------------
  logic [CNT_W-1:0] cnt_a [N_TMR];
  logic [CNT_W-1:0] rld_a [N_TMR];
  ctl_t             ctl_a [N_TMR];
  logic [N_TMR-1:0] fire_v, cnt_we_v, rld_we_v, ctl_we_v;
  logic [N_TMR-1:0] en_v, rs_v, ie_v, ip_v;

  for (genvar g = 0; g < N_TMR; g++) begin : g_chan
    logic hit;
    assign hit         = wr_cyc & (blk == 4'(g + 1));
    assign cnt_we_v[g] = hit & (slot == SLOT_A);
    assign rld_we_v[g] = hit & (slot == SLOT_B);
    assign ctl_we_v[g] = hit & (slot == SLOT_C);
    assign en_v[g]     = ctl_a[g].en;
    assign rs_v[g]     = ctl_a[g].rs;
    assign ie_v[g]     = ctl_a[g].ie;
    assign ip_v[g]     = ctl_a[g].ip;

    pscl_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .cnt_we (cnt_we_v[g]),
      .rld_we (rld_we_v[g]),
      .ctl_we (ctl_we_v[g]),
      .wdata  (pwdata[CNT_W-1:0]),
      .wctl   (pwdata[CTL_W-1:0]),
      .cnt    (cnt_a[g]),
      .rld    (rld_a[g]),
      .ctl    (ctl_a[g]),
      .fire   (fire_v[g])
    );
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (blk == 4'd0) begin
      case (slot)
        SLOT_A:  rd_mux = DATA_W'(pre_val);
        SLOT_B:  rd_mux = DATA_W'(pre_rld);
        SLOT_C:  rd_mux = CFG_WORD;
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < N_TMR; i++) begin
      if (blk == 4'(i + 1)) begin
        case (slot)
          SLOT_A:  rd_mux = DATA_W'(cnt_a[i]);
          SLOT_B:  rd_mux = DATA_W'(rld_a[i]);
          SLOT_C:  rd_mux = DATA_W'({ctl_a[i].dh, ctl_a[i].ch, ctl_a[i].ip,
                                     ctl_a[i].ie, 1'b0, ctl_a[i].rs, ctl_a[i].en});
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  // ---------------- interrupt routing ----------------
  always_comb begin
    irq = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (SEP_IRQ) irq[IRQ_BASE + i] = irq[IRQ_BASE + i] | fire_v[i];
      else         irq[IRQ_BASE]     = irq[IRQ_BASE] | fire_v[i];
    end
  end
endmodule

// File: rtl/pscl_timer_bank_chk.sv
module pscl_timer_bank_chk #(
  parameter int N     = 3,
  parameter int PRE_W = 16,
  parameter int N_IRQ = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             pre_val_we,
  input logic [PRE_W-1:0] pre_rld,
  input logic [N-1:0]     en,
  input logic [N-1:0]     rs,
  input logic [N-1:0]     ie,
  input logic [N-1:0]     ip,
  input logic [N-1:0]     fire,
  input logic [N-1:0]     ctl_we,
  input logic [N_IRQ-1:0] irq
);
  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_rld != '0 && !pre_val_we) |=> !tick);

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fire == '0) |-> (irq == '0));

  for (genvar g = 0; g < N; g++) begin : g_t
    // R7
    pend_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
      fire[g] |-> ip[g]);

    // R9
    fire_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
      fire[g] |-> $past(ie[g]));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(en[g]) && !$past(ctl_we[g])) |-> !rs[g]);
  end
endmodule

bind pscl_timer_bank pscl_timer_bank_chk #(
  .N     (N_TMR),
  .PRE_W (PRE_W),
  .N_IRQ (N_IRQ)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .pre_val_we (pre_val_we),
  .pre_rld    (pre_rld),
  .en         (en_v),
  .rs         (rs_v),
  .ie         (ie_v),
  .ip         (ip_v),
  .fire       (fire_v),
  .ctl_we     (ctl_we_v),
  .irq        (irq)
);

// File: tb/pscl_timer_bank_tb_top.sv
module pscl_timer_bank_tb_top;
  localparam int NI = 32;
  localparam int N_T = 3;
  localparam int CW = 16;
  localparam int BASE_A = 5;
  localparam int BASE_B = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_b;
  logic        pready, pready_b;
  logic [NI-1:0] irq_a, irq_b;

  always #2 clk = ~clk;  // 250 MHz

  pscl_timer_bank #(.N_TMR(N_T), .CNT_W(CW), .PRE_W(16), .IRQ_BASE(BASE_A),
                    .SEP_IRQ(1'b1), .NO_FREEZE(1'b0), .N_IRQ(NI)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq_a));

  pscl_timer_bank #(.N_TMR(N_T), .CNT_W(CW), .PRE_W(16), .IRQ_BASE(BASE_B),
                    .SEP_IRQ(1'b0), .NO_FREEZE(1'b0), .N_IRQ(NI)) dut_b (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .pready(pready_b), .irq(irq_b));

  int checks = 0, fails = 0, cyc = 0;
  int pc_a [NI];
  int pc_b [NI];
  int last_a [NI];
  int gap_a [NI];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int k = 0; k < NI; k++) begin
      pc_a[k] = 0; pc_b[k] = 0; last_a[k] = 0; gap_a[k] = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NI; k++) begin
        if (irq_a[k]) begin
          gap_a[k]  = cyc - last_a[k];
          last_a[k] = cyc;
          pc_a[k]   = pc_a[k] + 1;
        end
        if (irq_b[k]) pc_b[k] = pc_b[k] + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog (all reqs): cycles %0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [7:0] ta(input int t, input int slot);
    return 8'(16 + 16 * t + 4 * slot);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk("R13 pready", 32'(pready), 32'd1);
    chk("R7 irq idle after reset", irq_a, '0);
    rd(8'h04, v); chk("R1 prescaler reload reset", v, 32'd0);
    rd(ta(0, 2), v); chk("R3 control reset", v, 32'd0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    logic [31:0] exp;
    exp = 32'(N_T) | (32'(BASE_A) << 3) | (32'd1 << 8);
    rd(8'h08, v); chk("R2 config word", v, exp);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R2 config write ignored", v, exp);
  endtask

  task automatic t_load_width;
    logic [31:0] v;
    wr(ta(2, 1), 32'h1234);
    wr(ta(2, 2), 32'h04);
    rd(ta(2, 0), v); chk("R4 load copies reload", v, 32'h1234);
    rd(ta(2, 2), v); chk("R3 load bit reads 0", v, 32'h0);
    wr(ta(2, 0), 32'hFFFF_FFFF);
    rd(ta(2, 0), v); chk("R11 counter width", v, 32'h0000_FFFF);
    wr(ta(2, 1), 32'hFFFF_FFFF);
    rd(ta(2, 1), v); chk("R11 reload width", v, 32'h0000_FFFF);
  endtask

  task automatic t_ctl_bits;
    logic [31:0] v;
    wr(8'h04, 32'd0);
    wr(ta(2, 2), 32'h6F);
    rd(ta(2, 2), v); chk("R3 control read-back", v, 32'h6B);
    rd(ta(2, 0), v); chk("R12 counting with chain/halt set", 32'(v < 32'hFFFF), 32'd1);
    wr(ta(2, 2), 32'h00);
  endtask

  task automatic t_period(input int p, input int r, input logic [31:0] c,
                          input string tag);
    logic [31:0] v;
    int target;
    wr(8'h04, 32'(p));
    wr(ta(0, 1), 32'(r));
    rd(8'h04, v); chk("R1 prescaler reload read-back", v, 32'(p));
    rd(8'h00, v); chk("R1 prescaler value bounded", 32'(v <= 32'(p)), 32'd1);
    target = pc_a[BASE_A] + 3;
    wr(ta(0, 2), c);
    for (int w = 0; w < 2000 && pc_a[BASE_A] < target; w++) @(negedge clk);
    chk(tag, 32'(gap_a[BASE_A]), 32'((r + 1) * (p + 1)));
    wr(ta(0, 2), 32'h10);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int s6, s5, sb;
    wr(8'h04, 32'd0);
    s6 = pc_a[BASE_A + 1]; s5 = pc_a[BASE_A]; sb = pc_b[BASE_B];
    wr(ta(1, 1), 32'd2);
    wr(ta(1, 2), 32'h0D);
    repeat (20) @(negedge clk);
    rd(ta(1, 2), v); chk("R6 enable cleared, R7 pending set", v, 32'h18);
    rd(ta(1, 0), v); chk("R6 counter left at 0", v, 32'h0);
    chk("R7 single one-cycle pulse", 32'(pc_a[BASE_A + 1] - s6), 32'd1);
    chk("R10 separate line, other line quiet", 32'(pc_a[BASE_A] - s5), 32'd0);
    chk("R10 shared line", 32'(pc_b[BASE_B] - sb), 32'd1);
    wr(ta(1, 2), 32'h08);
    rd(ta(1, 2), v); chk("R8 write 0 keeps pending", v, 32'h18);
    wr(ta(1, 2), 32'h18);
    rd(ta(1, 2), v); chk("R8 write 1 clears pending", v, 32'h08);
  endtask

  task automatic t_no_ie;
    logic [31:0] v;
    int s6;
    s6 = pc_a[BASE_A + 1];
    wr(ta(1, 2), 32'h05);
    repeat (20) @(negedge clk);
    rd(ta(1, 2), v); chk("R9 no pending without ie", v, 32'h00);
    chk("R9 no pulse without ie", 32'(pc_a[BASE_A + 1] - s6), 32'd0);
  endtask

  task automatic t_map2;
    int s7, sb;
    s7 = pc_a[BASE_A + 2]; sb = pc_b[BASE_B];
    wr(ta(2, 1), 32'd1);
    wr(ta(2, 2), 32'h0D);
    repeat (20) @(negedge clk);
    chk("R10 timer 2 on base+2", 32'(pc_a[BASE_A + 2] - s7), 32'd1);
    chk("R10 timer 2 on shared base", 32'(pc_b[BASE_B] - sb), 32'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_config;
    t_load_width;
    t_ctl_bits;
    t_period(0, 3, 32'h0F, "R5 period p=0 r=3");
    t_period(2, 3, 32'h0F, "R5 period p=2 r=3");
    t_period(1, 4, 32'h6F, "R12 period with chain/halt");
    t_oneshot;
    t_no_ie;
    t_map2;
    chk("R13 pready after traffic", 32'(pready), 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule